// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This block formats data-side accesses between the execute stage and a word-wide data memory. For a store, it takes a byte address, an access size and the source register value. It returns a word-aligned memory address, a per-byte write enable and a write word with the source bytes placed in the lanes the address selects. For a load, it takes the same address and size, a sign-extension flag and the word the memory returned. It picks out the addressed byte or halfword and widens it to a full word.

Lane numbering is strictly little-endian: lane k carries the byte at word address plus k. Lane 0 is bits 7:0 and lane 3 is bits 31:24. A halfword or word access that would cross its natural boundary is not split. It is flagged on a fault output, and no byte is enabled. A parameter picks between a purely combinational formatter and one with a registered output stage.

Top module: `lsu_lane_align`

## Requirements
- R1: While reset is low, and in the cycle after it is released, every output is zero.
- R2: `mem_addr` equals `req_addr` with its two low bits cleared.
- R3: The size code is 00 for byte, 01 for halfword and 10 for word. Byte enables are one-hot at lane `req_addr[1:0]` for a byte access. They are 0011 or 1100 for a halfword access, chosen by `req_addr[1]`. They are 1111 for a word access.
- R4: Store data is laid out by size. A byte access repeats `st_data[7:0]` into all four lanes. A halfword access repeats `st_data[15:0]` into both halves. A word access passes `st_data` through unchanged. The upper bits of `st_data` never reach `mem_wdata` for byte and halfword accesses.
- R5: A byte load returns the byte in lane `req_addr[1:0]` of `mem_rdata`. It is sign-extended from its bit 7 when `req_signed` is 1 and zero-extended when it is 0.
- R6: A halfword load returns bits 15:0 or 31:16 of `mem_rdata`, chosen by `req_addr[1]`. It is sign-extended from its bit 15 when `req_signed` is 1 and zero-extended otherwise.
- R7: A word load returns `mem_rdata` unchanged, whatever `req_signed` is.
- R8: A halfword access with `req_addr[0]`=1, or a word access with `req_addr[1:0]`≠00, raises `align_fault`. It also clears all byte enables and forces `ld_data` to zero.
- R9: Size code 11 is reserved. It is treated as a misaligned access: fault raised, no byte enabled and `ld_data` zero.
- R10: With `PIPE_STAGES`=1, every output reflects the request presented one clock earlier. `out_valid` follows `req_valid` by one cycle.
- R11: A cycle without `req_valid` produces `out_valid`=0, `mem_be`=0000 and `align_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered variant and the checks) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_size | input | 2 | Access size code: 00 byte, 01 half, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend narrow loads when 1 |
| req_addr | input | ADDR_W | Byte effective address |
| st_data | input | DATA_W | Store source register value |
| mem_rdata | input | DATA_W | Word returned by the data memory |
| out_valid | output | 1 | Formatted access valid |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | DATA_W/8 | Per-lane byte enables |
| mem_wdata | output | DATA_W | Lane-placed store data |
| ld_data | output | DATA_W | Extracted and extended load result |
| align_fault | output | 1 | Misaligned or reserved-size access |

## Verification
The bench builds the block with its default 32-bit address and data and with `PIPE_STAGES`=1. In that configuration the registered stage, the reset values and the one-cycle latency can be observed. It visits every combination of size code, low address bits and signedness. The data patterns put a set top bit in different lanes, so each wrong extension or swapped lane shows up as a value mismatch. Random requests mixed with idle cycles then cover the gating of enables and faults when no request is present.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
   import lsa_pkg::*;
#(
   parameter int OFS_W = 2
) (
   input  acc_size_e        size,
   input  logic [OFS_W-1:0] ofs,
   output logic             misaligned
);

   always_comb begin
      unique case (size)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = ofs[0];
         SZ_WORD: misaligned = |ofs;
         default: misaligned = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
   import lsa_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFS_W = $clog2(LANES),
   localparam int DW    = LANES * 8
) (
   input  acc_size_e        size,
   input  logic [OFS_W-1:0] ofs,
   input  logic [DW-1:0]    src,
   output logic [LANES-1:0] be,
   output logic [DW-1:0]    lane_data
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(i);
      localparam int HALF_BYTE = i % 2;

      always_comb begin
         unique case (size)
            SZ_BYTE: begin
               be[i]              = (ofs == LANE_ID);
               lane_data[8*i +: 8] = src[7:0];
            end
            SZ_HALF: begin
               be[i]              = (ofs[OFS_W-1] == LANE_ID[OFS_W-1]);
               lane_data[8*i +: 8] = src[8*HALF_BYTE +: 8];
            end
            SZ_WORD: begin
               be[i]              = 1'b1;
               lane_data[8*i +: 8] = src[8*i +: 8];
            end
            default: begin
               be[i]              = 1'b0;
               lane_data[8*i +: 8] = src[8*i +: 8];
            end
         endcase
      end
   end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFS_W = $clog2(LANES),
   localparam int DW    = LANES * 8
) (
   input  acc_size_e        size,
   input  logic [OFS_W-1:0] ofs,
   input  logic             sext,
   input  logic [DW-1:0]    word,
   output logic [DW-1:0]    result
);

   logic [7:0]  pick_b;
   logic [15:0] pick_h;

   always_comb begin
      pick_b = word[{ofs, 3'b000} +: 8];
      pick_h = word[{ofs[OFS_W-1], 4'b0000} +: 16];
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: result = {{(DW-8){sext & pick_b[7]}}, pick_b};
         SZ_HALF: result = {{(DW-16){sext & pick_h[15]}}, pick_h};
         SZ_WORD: result = word;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lsa_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int PIPE_STAGES = 1,
   localparam int LANES      = DATA_W / 8,
   localparam int OFS_W      = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              out_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] ld_data,
   output logic              align_fault
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("lsu_lane_align: DATA_W must be 32");
   end
   if (PIPE_STAGES < 0 || PIPE_STAGES > 1) begin : g_bad_pipe
      $error("lsu_lane_align: PIPE_STAGES must be 0 or 1");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("lsu_lane_align: ADDR_W too small");
   end

   acc_size_e        size_q;
   logic [OFS_W-1:0] ofs;
   logic             mis;
   logic [LANES-1:0] be_raw;
   logic [DATA_W-1:0] wdata_raw;
   logic [DATA_W-1:0] ld_raw;

   assign size_q = acc_size_e'(req_size);
   assign ofs    = req_addr[OFS_W-1:0];

   lsa_align_chk #(.OFS_W(OFS_W)) u_chk (
      .size       (size_q),
      .ofs        (ofs),
      .misaligned (mis)
   );

   lsa_store_lane #(.LANES(LANES)) u_st (
      .size      (size_q),
      .ofs       (ofs),
      .src       (st_data),
      .be        (be_raw),
      .lane_data (wdata_raw)
   );

   lsa_load_extract #(.LANES(LANES)) u_ld (
      .size   (size_q),
      .ofs    (ofs),
      .sext   (req_signed),
      .word   (mem_rdata),
      .result (ld_raw)
   );

   logic              nx_valid;
   logic [ADDR_W-1:0] nx_addr;
   logic [LANES-1:0]  nx_be;
   logic [DATA_W-1:0] nx_wdata;
   logic [DATA_W-1:0] nx_ld;
   logic              nx_fault;

   always_comb begin
      nx_valid = req_valid;
      nx_addr  = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      nx_be    = (req_valid && !mis) ? be_raw : '0;
      nx_wdata = wdata_raw;
      nx_ld    = mis ? '0 : ld_raw;
      nx_fault = req_valid & mis;
   end

   if (PIPE_STAGES == 1) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            mem_addr    <= '0;
            mem_be      <= '0;
            mem_wdata   <= '0;
            ld_data     <= '0;
            align_fault <= 1'b0;
         end else begin
            out_valid   <= nx_valid;
            mem_addr    <= nx_addr;
            mem_be      <= nx_be;
            mem_wdata   <= nx_wdata;
            ld_data     <= nx_ld;
            align_fault <= nx_fault;
         end
      end

      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (out_valid == $past(req_valid)));

      // R2
      addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && out_valid) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(req_addr[ADDR_W-1:OFS_W])));
   end else begin : g_comb
      always_comb begin
         out_valid   = nx_valid;
         mem_addr    = nx_addr;
         mem_be      = nx_be;
         mem_wdata   = nx_wdata;
         ld_data     = nx_ld;
         align_fault = nx_fault;
      end
   end

   // R8
   fault_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (mem_be == '0 && ld_data == '0));

   // R3
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mem_be) != 3));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (mem_be == '0 && !align_fault));

   // R2
   word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr[OFS_W-1:0] == '0));

endmodule

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] st_data = '0;
   logic [31:0] mem_rdata = '0;
   logic        out_valid;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] ld_data;
   logic        align_fault;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct packed {
      logic        v;
      logic [1:0]  sz;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wd;
      logic [31:0] ld;
      logic        f;
   } exp_t;

   exp_t expq[$];

   always #2 clk = ~clk;

   lsu_lane_align #(.ADDR_W(32), .DATA_W(32), .PIPE_STAGES(1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
      .req_signed(req_signed), .req_addr(req_addr), .st_data(st_data),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .ld_data(ld_data),
      .align_fault(align_fault)
   );

   function automatic exp_t model(bit v, bit [1:0] sz, bit sg, bit [31:0] a,
                                  bit [31:0] sd, bit [31:0] rd);
      exp_t e;
      int off = int'(a & 32'd3);
      bit mis;
      bit [31:0] t;
      mis = (sz == 2'd3) || (sz == 2'd1 && (off % 2) == 1) || (sz == 2'd2 && off != 0);
      e.v = v; e.sz = sz; e.addr = a & 32'hFFFF_FFFC;
      case (sz)
         2'd0: begin
            e.be = 4'(1 << off); e.wd = (sd & 32'hFF) * 32'h0101_0101;
            t = (rd >> (8 * off)) & 32'hFF;
            if (sg && t >= 32'h80) t = t | 32'hFFFF_FF00;
         end
         2'd1: begin
            e.be = (off >= 2) ? 4'b1100 : 4'b0011; e.wd = (sd & 32'hFFFF) * 32'h0001_0001;
            t = (rd >> (16 * (off / 2))) & 32'hFFFF;
            if (sg && t >= 32'h8000) t = t | 32'hFFFF_0000;
         end
         2'd2: begin e.be = 4'hF; e.wd = sd; t = rd; end
         default: begin e.be = 4'h0; e.wd = sd; t = 0; end
      endcase
      if (mis) begin e.be = 4'h0; t = 0; end
      if (!v) e.be = 4'h0;
      e.ld = t;
      e.f  = v && mis;
      return e;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic compare_front();
      exp_t e;
      string lreq;
      if (expq.size() == 0) return;
      e = expq.pop_front();
      chk("R10 valid", 32'(out_valid), 32'(e.v));
      if (!e.v) begin
         chk("R11 be", 32'(mem_be), 32'h0);
         chk("R11 fault", 32'(align_fault), 32'h0);
         return;
      end
      chk(e.sz == 2'd3 ? "R9 fault" : "R8 fault", 32'(align_fault), 32'(e.f));
      chk(e.f ? "R8 be" : "R3 be", 32'(mem_be), 32'(e.be));
      chk("R2 addr", mem_addr, e.addr);
      if (!e.f) chk("R4 wdata", mem_wdata, e.wd);
      case (e.sz)
         2'd0: lreq = "R5 ld";
         2'd1: lreq = "R6 ld";
         2'd2: lreq = "R7 ld";
         default: lreq = "R9 ld";
      endcase
      if (e.f) lreq = (e.sz == 2'd3) ? "R9 ld" : "R8 ld";
      chk(lreq, ld_data, e.ld);
   endtask

   task automatic step(bit v, bit [1:0] sz, bit sg, bit [31:0] a,
                       bit [31:0] sd, bit [31:0] rd);
      @(negedge clk);
      compare_front();
      req_valid = v; req_size = sz; req_signed = sg; req_addr = a;
      st_data = sd; mem_rdata = rd;
      expq.push_back(model(v, sz, sg, a, sd, rd));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs zero while held in reset
      chk("R1 valid", 32'(out_valid), 0);
      chk("R1 be", 32'(mem_be), 0);
      chk("R1 wdata", mem_wdata, 0);
      chk("R1 ld", ld_data, 0);
      chk("R1 addr", mem_addr, 0);
      chk("R1 fault", 32'(align_fault), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: still zero one cycle after release (idle input)
      chk("R1 post valid", 32'(out_valid), 0);
      chk("R1 post ld", ld_data, 0);
      // Exhaustive directed sweep: R3 R4 R5 R6 R7 R8 R9
      for (int sz = 0; sz < 4; sz++)
         for (int off = 0; off < 4; off++)
            for (int sg = 0; sg < 2; sg++)
               for (int p = 0; p < 3; p++) begin
                  bit [31:0] rd;
                  bit [31:0] sd;
                  rd = (p == 0) ? 32'h8F7E_81FF : (p == 1) ? 32'h7F80_00FF : 32'h0123_8045;
                  sd = (p == 0) ? 32'hDEAD_BEEF : (p == 1) ? 32'h1234_5678 : 32'hA5C3_0F96;
                  step(1'b1, 2'(sz), 1'(sg), 32'h1000_0040 + 32'(off) + 32'(p * 8), sd, rd);
               end
      // R11: idle cycles with active-looking data
      step(1'b0, 2'd2, 1'b1, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      step(1'b0, 2'd3, 1'b0, 32'h0000_0001, 32'h1, 32'h2);
      // random mix, R10 back-to-back and gaps
      for (int k = 0; k < 400; k++)
         step(1'($urandom % 4 != 0), 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom);
      step(1'b0, 2'd0, 1'b0, 0, 0, 0);
      @(negedge clk);
      compare_front();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule